// File: doc/BRIEF.md
# Dual-Register Gray Pointer Counter

This block is a pointer counter for a queue whose two ends run on separate clocks. It keeps two registers side by side: a plain binary count and a Gray-coded copy of that count. On every clock edge the next binary value is formed once. That single value is written back to the binary register and is also converted to Gray and written to the Gray register. Because the Gray register is loaded from the converted next value, there is never a Gray-to-binary decode in the feedback loop. The cost is a second bank of flip-flops.

The Gray pointer is the value handed to the other clock domain. Between two advances it flips exactly one bit, so a comparator in the far domain never sees a false intermediate value. The low bits of the binary register address the storage array directly.

A request input asks for an advance. An inhibit input, normally driven by the full or empty flag of the surrounding queue, blocks that request. A parameter selects whether the Gray most significant bit has its own flip-flop or reuses the binary one. The two bits are always equal, so this is an area saving only.

Top module: `gray_ptr_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, both registers load zero: after that edge `gray_ptr` and `addr` read 0.
- R2: With `rst` low, `inc_req` high and `inhibit` low at an edge, the binary count rises by one. `addr` shows the low WIDTH-1 bits of the count after that edge.
- R3: With `rst` low and `inc_req` low, neither `gray_ptr` nor `addr` changes, whatever `inhibit` is.
- R4: With `rst` low and `inhibit` high, a high `inc_req` is ignored and both outputs hold.
- R5: `gray_ptr` always equals the held binary count B converted as B XOR (B shifted right by one). Decoding `gray_ptr` back to binary therefore gives `addr` in its low WIDTH-1 bits.
- R6: Every advance changes exactly one bit of `gray_ptr`.
- R7: From the all-ones count, an advance wraps the count to zero. At that wrap `gray_ptr` goes from a lone MSB (1 followed by zeros) to 0, so only the MSB changes.
- R8: With the shared-MSB option set to 1, the Gray MSB is taken from the binary MSB register. Its outputs match the default build cycle for cycle.
- R9: Reset takes priority: `rst` high together with an accepted increment request still clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the pointer's domain |
| rst | input | 1 | Synchronous active-high clear |
| inc_req | input | 1 | Request to advance the pointer |
| inhibit | input | 1 | Blocks the request (full/empty of the queue) |
| gray_ptr | output | WIDTH | Registered Gray-coded pointer |
| addr | output | WIDTH-1 | Low binary bits used as storage address |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the synchronous clear and an accepted advance. The bench drives `rst` high together with `inc_req` high, both from a count of zero and from a nonzero count. It then judges that both outputs read zero after the edge rather than one step on. The second pair is the wrap and the one-bit-change rule, which coincide at the all-ones count. There the bench checks that the Gray transition is exactly the MSB dropping from the lone-MSB code to zero. A second instance built with the shared MSB runs in lockstep and must match the first on every cycle.

// File: rtl/gcc_pkg.sv
package gcc_pkg;

    localparam int MAX_W = 32;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_ADV   = 2'd1,
        STEP_CLEAR = 2'd2
    } step_kind_e;

    // One two-input XOR per bit: bit i = b[i] ^ b[i+1]
    function automatic logic [MAX_W-1:0] bin_to_gray(input logic [MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Priority: clear beats advance, advance needs request without inhibit
    function automatic step_kind_e decode_step(input logic clr, input logic req,
                                               input logic blk);
        if (clr)
            return STEP_CLEAR;
        else if (req && !blk)
            return STEP_ADV;
        else
            return STEP_HOLD;
    endfunction

endpackage

// File: rtl/gcc_ctl.sv
module gcc_ctl
    import gcc_pkg::*;
(
    input  logic       rst,
    input  logic       inc_req,
    input  logic       inhibit,
    output step_kind_e step
);

    always_comb begin
        step = decode_step(rst, inc_req, inhibit);
    end

endmodule

// File: rtl/gcc_next.sv
module gcc_next
    import gcc_pkg::*;
#(
    parameter int WIDTH = 5,
    parameter int GW    = 5
) (
    input  step_kind_e       step,
    input  logic [WIDTH-1:0] cur_bin,
    output logic [WIDTH-1:0] next_bin,
    output logic [GW-1:0]    next_gray
);

    always_comb begin
        unique case (step)
            STEP_CLEAR: next_bin = '0;
            STEP_ADV:   next_bin = cur_bin + 1'b1;
            default:    next_bin = cur_bin;
        endcase
    end

    // Gray is formed from the next binary value, not from the held Gray
    always_comb begin
        next_gray = GW'(bin_to_gray(MAX_W'(next_bin)));
    end

endmodule

// File: rtl/gcc_reg.sv
module gcc_reg #(
    parameter int WIDTH     = 5,
    parameter int SHARE_MSB = 0,
    parameter int GW        = 5
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] next_bin,
    input  logic [GW-1:0]    next_gray,
    output logic [WIDTH-1:0] bin_q,
    output logic [WIDTH-1:0] gray_q
);

    logic [GW-1:0] gray_r;

    always_ff @(posedge clk) begin
        bin_q  <= next_bin;
        gray_r <= next_gray;
    end

    generate
        if (SHARE_MSB != 0) begin : g_shared_msb
            // Gray MSB equals binary MSB: reuse that flip-flop
            assign gray_q = {bin_q[WIDTH-1], gray_r};
        end else begin : g_own_msb
            assign gray_q = gray_r;
        end
    endgenerate

endmodule

// File: rtl/gray_ptr_counter.sv
module gray_ptr_counter
    import gcc_pkg::*;
#(
    parameter int WIDTH     = 5,
    parameter int SHARE_MSB = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_req,
    input  logic             inhibit,
    output logic [WIDTH-1:0] gray_ptr,
    output logic [WIDTH-2:0] addr
);

    localparam int AW = WIDTH - 1;
    localparam int GW = (SHARE_MSB != 0) ? WIDTH - 1 : WIDTH;

    step_kind_e       step;
    logic [WIDTH-1:0] bin_q;
    logic [WIDTH-1:0] next_bin;
    logic [GW-1:0]    next_gray;

    gcc_ctl u_ctl (
        .rst     (rst),
        .inc_req (inc_req),
        .inhibit (inhibit),
        .step    (step)
    );

    gcc_next #(.WIDTH(WIDTH), .GW(GW)) u_next (
        .step      (step),
        .cur_bin   (bin_q),
        .next_bin  (next_bin),
        .next_gray (next_gray)
    );

    gcc_reg #(.WIDTH(WIDTH), .SHARE_MSB(SHARE_MSB), .GW(GW)) u_reg (
        .clk       (clk),
        .next_bin  (next_bin),
        .next_gray (next_gray),
        .bin_q     (bin_q),
        .gray_q    (gray_ptr)
    );

    assign addr = bin_q[AW-1:0];

endmodule

// File: rtl/gray_ptr_counter_chk.sv
module gray_ptr_counter_chk #(
    parameter int WIDTH = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             inc_req,
    input logic             inhibit,
    input logic [WIDTH-1:0] gray_ptr,
    input logic [WIDTH-2:0] addr
);

    localparam int AW = WIDTH - 1;
    localparam logic [WIDTH-1:0] LONE_MSB = {1'b1, {(WIDTH-1){1'b0}}};

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (gray_ptr == '0 && addr == '0));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (inc_req && !inhibit) |=> (addr == AW'($past(addr) + 1'b1)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !inc_req |=> ($stable(gray_ptr) && $stable(addr)));

    p_inhibit_r4: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> ($stable(gray_ptr) && $stable(addr)));

    p_one_bit_r6: assert property (@(posedge clk) disable iff (rst)
        (inc_req && !inhibit) |=> ($countones(gray_ptr ^ $past(gray_ptr)) == 1));

    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (inc_req && !inhibit && gray_ptr == LONE_MSB) |=> (gray_ptr == '0));

    generate
        if (AW >= 2) begin : g_map
            p_gray_map_r5: assert property (@(posedge clk) disable iff (rst)
                gray_ptr[AW-2:0] == (addr[AW-2:0] ^ addr[AW-1:1]));
        end
    endgenerate

endmodule

bind gray_ptr_counter gray_ptr_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .inc_req  (inc_req),
    .inhibit  (inhibit),
    .gray_ptr (gray_ptr),
    .addr     (addr)
);

// File: tb/sim_gray_ptr_counter.sv
module sim_gray_ptr_counter;

    localparam int W  = 5;
    localparam int AW = W - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inc_req = 1'b0;
    logic inhibit = 1'b0;
    logic [W-1:0]  gray0, gray1;
    logic [AW-1:0] addr0, addr1;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] exp_bin = '0;
    logic [W-1:0] prev_gray = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gray_ptr_counter #(.WIDTH(W), .SHARE_MSB(0)) u0 (
        .clk(clk), .rst(rst), .inc_req(inc_req), .inhibit(inhibit),
        .gray_ptr(gray0), .addr(addr0));

    gray_ptr_counter #(.WIDTH(W), .SHARE_MSB(1)) u1 (
        .clk(clk), .rst(rst), .inc_req(inc_req), .inhibit(inhibit),
        .gray_ptr(gray1), .addr(addr1));

    function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
        logic [W-1:0] g;
        g[W-1] = b[W-1];
        for (int i = 0; i < W - 1; i++) g[i] = b[i] ^ b[i+1];
        return g;
    endfunction

    function automatic logic [W-1:0] from_gray(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic i, input logic h, input string req);
        logic adv;
        @(negedge clk);
        rst = r; inc_req = i; inhibit = h;
        prev_gray = gray0;
        @(posedge clk);
        #1;
        adv = !r && i && !h;
        if (r) exp_bin = '0;
        else if (adv) exp_bin = exp_bin + 1'b1;
        chk({req, " gray"}, gray0, to_gray(exp_bin));
        chk({req, " addr"}, {1'b0, addr0}, {1'b0, exp_bin[AW-1:0]});
        chk("R5 decode", {1'b0, from_gray(gray0)[AW-1:0]}, {1'b0, addr0});
        chk("R8 gray match", gray1, gray0);
        chk("R8 addr match", {1'b0, addr1}, {1'b0, addr0});
        if (adv) chk("R6 one bit", W'($countones(gray0 ^ prev_gray)), W'(1));
    endtask

    task automatic t_reset;
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b1, "R1");
        step(1'b1, 1'b1, 1'b0, "R9");
    endtask

    task automatic t_count;
        for (int k = 0; k < 7; k++) step(1'b0, 1'b1, 1'b0, "R2");
    endtask

    task automatic t_hold;
        step(1'b0, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_inhibit;
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b1, "R4");
    endtask

    task automatic t_wrap;
        while (exp_bin != {W{1'b1}}) step(1'b0, 1'b1, 1'b0, "R2");
        chk("R7 lone msb before", gray0, {1'b1, {(W-1){1'b0}}});
        step(1'b0, 1'b1, 1'b0, "R7");
        chk("R7 zero after", gray0, '0);
        chk("R7 msb only", prev_gray ^ gray0, {1'b1, {(W-1){1'b0}}});
    endtask

    task automatic t_reset_mid;
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b1, 1'b1, 1'b0, "R9");
        chk("R9 cleared", gray0, '0);
    endtask

    task automatic t_mixed;
        logic [7:0] lf = 8'hA5;
        for (int k = 0; k < 150; k++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step(1'b0, lf[0] | lf[3], lf[1] & lf[2], "R5");
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_count;
        t_hold;
        t_inhibit;
        t_wrap;
        t_reset_mid;
        t_mixed;
        t_wrap;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule